// File: doc/BRIEF.md
# Command Queue Trigger Controller

This block decides when a single command queue may pass its next command to a serial link that feeds a converter. Software selects one of six operating modes. The block combines that mode with an external trigger or gate input, a start bit for single scans, a grant from an outside priority arbiter, and a ready signal from the downstream target. From these it produces a one-cycle issue strobe and keeps a read pointer into the queue storage. It also counts completed serial transfers.

The queue storage lives outside the block. It presents the end-of-queue and pause bits of the command at the current read pointer. The serial engine reports each finished transfer with a one-cycle done pulse. The block raises three sticky flags (pause, end-of-queue, trigger overrun). Each flag is cleared by writing one to it, and each has its own interrupt enable.

Top module: `cq_trigger_ctrl`

## Requirements
- R1: During and after a synchronous reset, the status is IDLE (status_o = 0), the start bit is 0, the read pointer equals BASE, the transfer counter is 0, and all flags and interrupts are 0.
- R2: An issue strobe occurs only in a cycle where all of these hold: the status is TRIGGERED (status_o = 1), grant_i and tgt_ready_i are high, and no transfer is in flight. A transfer is in flight from its issue until its xfer_done_i. Each issue advances the read pointer by one, or returns it to BASE when the issued command carries end-of-queue. The pointer changes at no other time, except when the mode is disabled.
- R3: The transfer counter increases by one, modulo 2^CNT_W, on every xfer_done_i pulse. It holds otherwise.
- R4: Mode encoding is 0 disabled, 1 single-scan gated, 2 continuous software-triggered, 3 rising edge, 4 falling edge, 5 either edge. Codes 6 and 7 act as disabled. While disabled, the status is IDLE and the read pointer returns to BASE.
- R5: In mode 2, the status becomes TRIGGERED on the edge after the mode is applied. An end-of-queue command sets the end-of-queue flag (bit 1) and wraps the pointer, but transfers continue. The pause bit of a command is ignored.
- R6: In mode 1, an IDLE queue becomes TRIGGERED when the start bit is set and the synchronized gate is high. Issuing an end-of-queue command sets flag bit 1, returns the status to IDLE and clears the start bit. The pause bit of a command is ignored.
- R7: In mode 1, if the gate is low while the status is TRIGGERED and no transfer is in flight, the status goes IDLE, the start bit clears, and the pause flag (bit 0) is set.
- R8: In mode 1, if the gate goes low while a transfer is in flight, the status is unchanged until xfer_done_i. If the gate is still low at that done, the counter advances, the status goes IDLE, the start bit clears and the pause flag is set.
- R9: In mode 1, if the gate goes low and back high within one transfer, the status and the pause flag are unchanged, and the overrun flag (bit 2) is set at that done.
- R10: After a gate closure, setting the start bit again with the gate high resumes issue from the read pointer where it stopped.
- R11: In modes 3 to 5, the trigger input passes a two-flop synchronizer. The selected edge moves an IDLE queue to TRIGGERED, and other edges have no effect. Issuing a command with end-of-queue or pause returns the status to IDLE and sets the matching flag (end-of-queue wins if both are set). The next qualifying edge resumes issue.
- R12: A qualifying edge that arrives while the status is already TRIGGERED sets the overrun flag (bit 2).
- R13: Writing one to a bit of flag_clr_i clears that flag, and a zero bit leaves it unchanged. A set in the same cycle wins over a clear. Each irq_o bit is, one edge later, the flag ANDed with its enable in irq_en_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 3 | Operating mode code |
| sss_set_i | input | 1 | Pulse that sets the single-scan start bit |
| trig_i | input | 1 | Asynchronous trigger or gate input |
| grant_i | input | 1 | Grant from the queue arbiter |
| tgt_ready_i | input | 1 | Downstream target can accept a command |
| cmd_eoq_i | input | 1 | End-of-queue bit of the command at the read pointer |
| cmd_pause_i | input | 1 | Pause bit of the command at the read pointer |
| xfer_done_i | input | 1 | Serial transfer finished (one-cycle pulse) |
| flag_clr_i | input | 3 | Write-one-to-clear for the flags |
| irq_en_i | input | 3 | Interrupt enables per flag |
| status_o | output | 1 | 1 = TRIGGERED, 0 = IDLE |
| sss_o | output | 1 | Single-scan start bit |
| issue_o | output | 1 | Command handed to the serial engine this cycle |
| rd_ptr_o | output | PTR_W | Command read pointer |
| xfer_cnt_o | output | CNT_W | Completed transfer count |
| flags_o | output | 3 | Flags: bit 0 pause, bit 1 end-of-queue, bit 2 overrun |
| irq_o | output | 3 | Interrupt requests per flag |

## Verification
The bench builds the block with PTR_W = 3, CNT_W = 4 and BASE = 1. With this nonzero base, a wrap after end-of-queue is visibly different from a plain counter rollover. With a 16-entry counter, the number of transfers in one run carries the count past its wrap. The bench's command model places a pause at address 2 and an end-of-queue at address 4, so every mode meets both bits within a few commands. Making the serial engine model's transfer length adjustable lets gate closures and short gate blips land inside a transfer.

// File: rtl/cqt_pkg.sv
package cqt_pkg;
  typedef enum logic [2:0] {
    MD_OFF    = 3'd0,
    MD_GATED  = 3'd1,
    MD_SWLOOP = 3'd2,
    MD_RISE   = 3'd3,
    MD_FALL   = 3'd4,
    MD_ANY    = 3'd5
  } cq_mode_e;

  localparam int FL_PAUSE = 0;
  localparam int FL_EOQ   = 1;
  localparam int FL_OVR   = 2;
  localparam int FL_N     = 3;
endpackage

// File: rtl/cqt_trig_sync.sv
module cqt_trig_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic trig_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[0] <= 1'b0;
          else     chain_q[0] <= trig_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[s] <= 1'b0;
          else     chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= chain_q[STAGES-1];
  end

  assign level_o = chain_q[STAGES-1];
  assign rise_o  = chain_q[STAGES-1] & ~prev_q;
  assign fall_o  = ~chain_q[STAGES-1] & prev_q;
endmodule

// File: rtl/cqt_flag_bank.sv
module cqt_flag_bank #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] en_i,
  output logic [N-1:0] flags_o,
  output logic [N-1:0] irq_o
);
  generate
    for (genvar b = 0; b < N; b++) begin : g_flag
      logic nxt;
      // a set in the same cycle wins over a clear
      assign nxt = set_i[b] | (flags_o[b] & ~clr_i[b]);
      always_ff @(posedge clk) begin
        if (rst) begin
          flags_o[b] <= 1'b0;
          irq_o[b]   <= 1'b0;
        end else begin
          flags_o[b] <= nxt;
          irq_o[b]   <= nxt & en_i[b];
        end
      end
    end
  endgenerate
endmodule

// File: rtl/cqt_seq.sv
module cqt_seq
  import cqt_pkg::*;
#(
  parameter int PTR_W = 4,
  parameter int CNT_W = 8,
  parameter int BASE  = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       mode_i,
  input  logic             sss_set_i,
  input  logic             gate_i,
  input  logic             rise_i,
  input  logic             fall_i,
  input  logic             grant_i,
  input  logic             tgt_ready_i,
  input  logic             cmd_eoq_i,
  input  logic             cmd_pause_i,
  input  logic             xfer_done_i,
  output logic             status_o,
  output logic             sss_o,
  output logic             issue_o,
  output logic [PTR_W-1:0] rd_ptr_o,
  output logic [CNT_W-1:0] xfer_cnt_o,
  output logic [FL_N-1:0]  flag_set_o
);
  localparam logic [PTR_W-1:0] PTR_BASE = PTR_W'(BASE);

  logic             status_q, status_n;
  logic             sss_q, sss_n;
  logic             busy_q, busy_n;
  logic             closed_q, closed_n;
  logic [PTR_W-1:0] ptr_q, ptr_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;

  logic is_gated, is_sw, is_edge, is_off, qual_edge, issue;

  assign is_gated = (mode_i == MD_GATED);
  assign is_sw    = (mode_i == MD_SWLOOP);
  assign is_edge  = (mode_i == MD_RISE) || (mode_i == MD_FALL) || (mode_i == MD_ANY);
  assign is_off   = !(is_gated || is_sw || is_edge);

  assign qual_edge = ((mode_i == MD_RISE) && rise_i) ||
                     ((mode_i == MD_FALL) && fall_i) ||
                     ((mode_i == MD_ANY)  && (rise_i || fall_i));

  assign issue = status_q && grant_i && tgt_ready_i && !busy_q && !is_off &&
                 !(is_gated && !gate_i);

  always_comb begin
    status_n   = status_q;
    sss_n      = sss_q | sss_set_i;
    busy_n     = busy_q;
    ptr_n      = ptr_q;
    cnt_n      = cnt_q;
    flag_set_o = '0;

    if (xfer_done_i) cnt_n = cnt_q + 1'b1;

    if (issue)            busy_n = 1'b1;
    else if (xfer_done_i) busy_n = 1'b0;

    // remember a gate closure seen during the transfer in flight
    if (busy_q && !xfer_done_i) closed_n = closed_q | (is_gated & ~gate_i);
    else                        closed_n = 1'b0;

    if (issue) begin
      ptr_n = cmd_eoq_i ? PTR_BASE : ptr_q + 1'b1;
      if (cmd_eoq_i) flag_set_o[FL_EOQ] = 1'b1;
    end

    if (is_off) begin
      status_n = 1'b0;
      ptr_n    = PTR_BASE;
    end else if (is_sw) begin
      status_n = 1'b1;
    end else if (is_gated) begin
      if (!status_q) begin
        if (sss_q && gate_i) status_n = 1'b1;
      end else if (issue && cmd_eoq_i) begin
        status_n = 1'b0;
        sss_n    = 1'b0;
      end else if (!busy_q && !gate_i) begin
        status_n = 1'b0;
        sss_n    = 1'b0;
        flag_set_o[FL_PAUSE] = 1'b1;
      end else if (busy_q && xfer_done_i) begin
        if (!gate_i) begin
          status_n = 1'b0;
          sss_n    = 1'b0;
          flag_set_o[FL_PAUSE] = 1'b1;
        end else if (closed_q) begin
          flag_set_o[FL_OVR] = 1'b1;
        end
      end
    end else begin
      if (issue && (cmd_eoq_i || cmd_pause_i)) begin
        status_n = 1'b0;
        if (!cmd_eoq_i) flag_set_o[FL_PAUSE] = 1'b1;
      end else if (qual_edge && !status_q) begin
        status_n = 1'b1;
      end
      if (qual_edge && status_q) flag_set_o[FL_OVR] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= 1'b0;
      sss_q    <= 1'b0;
      busy_q   <= 1'b0;
      closed_q <= 1'b0;
      ptr_q    <= PTR_BASE;
      cnt_q    <= '0;
    end else begin
      status_q <= status_n;
      sss_q    <= sss_n;
      busy_q   <= busy_n;
      closed_q <= closed_n;
      ptr_q    <= ptr_n;
      cnt_q    <= cnt_n;
    end
  end

  assign status_o   = status_q;
  assign sss_o      = sss_q;
  assign issue_o    = issue;
  assign rd_ptr_o   = ptr_q;
  assign xfer_cnt_o = cnt_q;
endmodule

// File: rtl/cq_trigger_ctrl.sv
module cq_trigger_ctrl
  import cqt_pkg::*;
#(
  parameter int PTR_W       = 4,
  parameter int CNT_W       = 8,
  parameter int BASE        = 0,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       mode_i,
  input  logic             sss_set_i,
  input  logic             trig_i,
  input  logic             grant_i,
  input  logic             tgt_ready_i,
  input  logic             cmd_eoq_i,
  input  logic             cmd_pause_i,
  input  logic             xfer_done_i,
  input  logic [2:0]       flag_clr_i,
  input  logic [2:0]       irq_en_i,
  output logic             status_o,
  output logic             sss_o,
  output logic             issue_o,
  output logic [PTR_W-1:0] rd_ptr_o,
  output logic [CNT_W-1:0] xfer_cnt_o,
  output logic [2:0]       flags_o,
  output logic [2:0]       irq_o
);
  logic            gate_lvl, gate_rise, gate_fall;
  logic [FL_N-1:0] flag_set;

  cqt_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .trig_i  (trig_i),
    .level_o (gate_lvl),
    .rise_o  (gate_rise),
    .fall_o  (gate_fall)
  );

  cqt_seq #(.PTR_W(PTR_W), .CNT_W(CNT_W), .BASE(BASE)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .mode_i      (mode_i),
    .sss_set_i   (sss_set_i),
    .gate_i      (gate_lvl),
    .rise_i      (gate_rise),
    .fall_i      (gate_fall),
    .grant_i     (grant_i),
    .tgt_ready_i (tgt_ready_i),
    .cmd_eoq_i   (cmd_eoq_i),
    .cmd_pause_i (cmd_pause_i),
    .xfer_done_i (xfer_done_i),
    .status_o    (status_o),
    .sss_o       (sss_o),
    .issue_o     (issue_o),
    .rd_ptr_o    (rd_ptr_o),
    .xfer_cnt_o  (xfer_cnt_o),
    .flag_set_o  (flag_set)
  );

  cqt_flag_bank #(.N(FL_N)) u_flags (
    .clk     (clk),
    .rst     (rst),
    .set_i   (flag_set),
    .clr_i   (flag_clr_i),
    .en_i    (irq_en_i),
    .flags_o (flags_o),
    .irq_o   (irq_o)
  );
endmodule

// File: rtl/cqt_checker.sv
module cqt_checker #(
  parameter int PTR_W = 4,
  parameter int CNT_W = 8,
  parameter int BASE  = 0
) (
  input logic             clk,
  input logic             rst,
  input logic [2:0]       mode_i,
  input logic             grant_i,
  input logic             tgt_ready_i,
  input logic             xfer_done_i,
  input logic             status_o,
  input logic             issue_o,
  input logic [PTR_W-1:0] rd_ptr_o,
  input logic [CNT_W-1:0] xfer_cnt_o,
  input logic [2:0]       flags_o,
  input logic [2:0]       irq_o
);
  logic mode_off;
  assign mode_off = (mode_i == 3'd0) || (mode_i > 3'd5);

  a_r2_issue_gated: assert property (@(posedge clk) disable iff (rst)
    issue_o |-> (status_o && grant_i && tgt_ready_i));

  a_r2_single_flight: assert property (@(posedge clk) disable iff (rst)
    issue_o |=> !issue_o);

  a_r2_ptr_steady: assert property (@(posedge clk) disable iff (rst)
    (!issue_o && !mode_off) |=> $stable(rd_ptr_o));

  a_r3_count_step: assert property (@(posedge clk) disable iff (rst)
    xfer_done_i |=> (xfer_cnt_o == CNT_W'($past(xfer_cnt_o) + 1'b1)));

  a_r3_count_hold: assert property (@(posedge clk) disable iff (rst)
    !xfer_done_i |=> $stable(xfer_cnt_o));

  a_r4_off_idle: assert property (@(posedge clk) disable iff (rst)
    mode_off |=> (!status_o && rd_ptr_o == PTR_W'(BASE)));

  a_r5_sw_running: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 3'd2) |=> status_o);

  a_r13_irq_needs_flag: assert property (@(posedge clk) disable iff (rst)
    (irq_o & ~flags_o) == 3'b000);
endmodule

bind cq_trigger_ctrl cqt_checker #(.PTR_W(PTR_W), .CNT_W(CNT_W), .BASE(BASE)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .mode_i      (mode_i),
  .grant_i     (grant_i),
  .tgt_ready_i (tgt_ready_i),
  .xfer_done_i (xfer_done_i),
  .status_o    (status_o),
  .issue_o     (issue_o),
  .rd_ptr_o    (rd_ptr_o),
  .xfer_cnt_o  (xfer_cnt_o),
  .flags_o     (flags_o),
  .irq_o       (irq_o)
);

// File: tb/tb_cq_trigger_ctrl.sv
module tb_cq_trigger_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int PW = 3;
  localparam int CW = 4;
  localparam int QB = 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [2:0]    mode_i = 3'd0;
  logic          sss_set_i = 1'b0;
  logic          trig_i = 1'b0;
  logic          grant_i = 1'b0;
  logic          tgt_ready_i = 1'b1;
  logic          cmd_eoq_i, cmd_pause_i;
  logic          xfer_done_i = 1'b0;
  logic [2:0]    flag_clr_i = 3'b000;
  logic [2:0]    irq_en_i = 3'b000;
  logic          status_o, sss_o, issue_o;
  logic [PW-1:0] rd_ptr_o;
  logic [CW-1:0] xfer_cnt_o;
  logic [2:0]    flags_o, irq_o;

  int n_checks = 0;
  int n_fail   = 0;
  int sb[$];
  int eng_cnt  = 0;
  int xlen     = 4;
  int dones    = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // command storage model: pause at address 2, end-of-queue at address 4
  assign cmd_pause_i = (rd_ptr_o == 3'd2);
  assign cmd_eoq_i   = (rd_ptr_o == 3'd4);

  cq_trigger_ctrl #(.PTR_W(PW), .CNT_W(CW), .BASE(QB)) dut (
    .clk(clk), .rst(rst), .mode_i(mode_i), .sss_set_i(sss_set_i),
    .trig_i(trig_i), .grant_i(grant_i), .tgt_ready_i(tgt_ready_i),
    .cmd_eoq_i(cmd_eoq_i), .cmd_pause_i(cmd_pause_i),
    .xfer_done_i(xfer_done_i), .flag_clr_i(flag_clr_i), .irq_en_i(irq_en_i),
    .status_o(status_o), .sss_o(sss_o), .issue_o(issue_o),
    .rd_ptr_o(rd_ptr_o), .xfer_cnt_o(xfer_cnt_o), .flags_o(flags_o),
    .irq_o(irq_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic expect_issue(input int p);
    sb.push_back(p);
  endtask

  task automatic drain();
    while (sb.size() != 0) tick(1);
    while (eng_cnt != 0 || xfer_done_i) tick(1);
    tick(2);
  endtask

  task automatic clear_flags();
    flag_clr_i = 3'b111;
    tick(1);
    flag_clr_i = 3'b000;
  endtask

  task automatic pulse_start();
    sss_set_i = 1'b1;
    tick(1);
    sss_set_i = 1'b0;
  endtask

  // monitor (scoreboard pop) and serial engine model
  always @(negedge clk) begin
    if (xfer_done_i) xfer_done_i = 1'b0;
    if (!rst && issue_o) begin
      if (sb.size() == 0) begin
        n_checks++;
        n_fail++;
        $display("FAIL R2: unexpected issue at pointer %0d, expected none", rd_ptr_o);
      end else begin
        check("R2 issue pointer", int'(rd_ptr_o), sb.pop_front());
      end
      eng_cnt = xlen;
    end else if (eng_cnt > 0) begin
      eng_cnt--;
      if (eng_cnt == 0) begin
        xfer_done_i = 1'b1;
        dones++;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    tick(3);
    check("R1 status", status_o, 0);
    check("R1 pointer", rd_ptr_o, QB);
    check("R1 counter", xfer_cnt_o, 0);
    check("R1 flags", flags_o, 0);
    rst = 1'b0;
    tick(1);
    check("R1 start bit", sss_o, 0);
    check("R1 irq", irq_o, 0);

    // R5: continuous software mode, pause ignored, eoq wraps and continues
    mode_i = 3'd2;
    tick(1);
    check("R5 triggered", status_o, 1);
    check("R2 no grant no issue", rd_ptr_o, QB);
    for (int k = 0; k < 6; k++) expect_issue(((k % 4) + 1));
    grant_i = 1'b1;
    while (sb.size() != 0) tick(1);
    grant_i = 1'b0;
    check("R5 still triggered", status_o, 1);
    check("R5 eoq flag", flags_o[1], 1);
    check("R5 pause ignored", flags_o[0], 0);
    drain();
    mode_i = 3'd0;
    tick(1);
    check("R4 off idle", status_o, 0);
    check("R4 pointer base", rd_ptr_o, QB);
    mode_i = 3'd7;
    tick(2);
    check("R4 code 7 idle", status_o, 0);
    check("R3 counter", xfer_cnt_o, dones % 16);
    clear_flags();
    check("R13 cleared", flags_o, 0);

    // R6: single scan, pause ignored, eoq ends the scan
    mode_i = 3'd1;
    trig_i = 1'b1;
    tick(4);
    check("R6 idle without start", status_o, 0);
    for (int k = 1; k <= 4; k++) expect_issue(k);
    grant_i = 1'b1;
    pulse_start();
    drain();
    check("R6 idle after eoq", status_o, 0);
    check("R6 start cleared", sss_o, 0);
    check("R6 eoq flag", flags_o[1], 1);
    check("R6 pause ignored", flags_o[0], 0);
    check("R6 pointer wrapped", rd_ptr_o, QB);
    clear_flags();

    // R7: gate closes with nothing in flight
    grant_i = 1'b0;
    pulse_start();
    tick(2);
    check("R7 triggered", status_o, 1);
    trig_i = 1'b0;
    tick(5);
    check("R7 idle", status_o, 0);
    check("R7 start cleared", sss_o, 0);
    check("R7 pause flag", flags_o[0], 1);
    clear_flags();

    // R8: gate closes during a transfer
    trig_i = 1'b1;
    tick(4);
    xlen = 12;
    expect_issue(1);
    grant_i = 1'b1;
    pulse_start();
    while (sb.size() != 0) tick(1);
    trig_i = 1'b0;
    tick(5);
    check("R8 deferred status", status_o, 1);
    check("R8 deferred pause", flags_o[0], 0);
    drain();
    check("R8 idle after done", status_o, 0);
    check("R8 pause flag", flags_o[0], 1);
    check("R8 start cleared", sss_o, 0);
    check("R8 counter", xfer_cnt_o, dones % 16);
    check("R8 pointer", rd_ptr_o, 2);
    clear_flags();

    // R10: restart continues where it stopped
    xlen = 4;
    trig_i = 1'b1;
    tick(4);
    for (int k = 2; k <= 4; k++) expect_issue(k);
    pulse_start();
    drain();
    check("R10 resumed to eoq", flags_o[1], 1);
    check("R10 pointer", rd_ptr_o, QB);
    clear_flags();

    // R9: gate blip inside one transfer
    xlen = 12;
    expect_issue(1);
    pulse_start();
    while (sb.size() != 0) tick(1);
    grant_i = 1'b0;
    trig_i = 1'b0;
    tick(3);
    trig_i = 1'b1;
    drain();
    check("R9 status kept", status_o, 1);
    check("R9 no pause", flags_o[0], 0);
    check("R9 overrun", flags_o[2], 1);
    mode_i = 3'd0;
    trig_i = 1'b0;
    tick(4);
    clear_flags();

    // R11: rising edge mode, pause and eoq halt
    xlen = 4;
    mode_i = 3'd3;
    grant_i = 1'b1;
    tick(3);
    check("R11 idle before edge", status_o, 0);
    expect_issue(1);
    expect_issue(2);
    trig_i = 1'b1;
    drain();
    check("R11 halted on pause", status_o, 0);
    check("R11 pause flag", flags_o[0], 1);
    check("R11 pointer", rd_ptr_o, 3);
    trig_i = 1'b0;
    tick(5);
    check("R11 falling ignored", status_o, 0);
    expect_issue(3);
    expect_issue(4);
    trig_i = 1'b1;
    drain();
    check("R11 halted on eoq", status_o, 0);
    check("R11 eoq flag", flags_o[1], 1);
    check("R11 pointer wrapped", rd_ptr_o, QB);
    clear_flags();

    // R12: second edge while triggered
    grant_i = 1'b0;
    irq_en_i = 3'b100;
    trig_i = 1'b0;
    tick(4);
    trig_i = 1'b1;
    tick(4);
    check("R12 triggered", status_o, 1);
    check("R12 no overrun yet", flags_o[2], 0);
    trig_i = 1'b0;
    tick(4);
    trig_i = 1'b1;
    tick(4);
    check("R12 overrun", flags_o[2], 1);
    check("R13 irq follows enable", irq_o, 3'b100);
    flag_clr_i = 3'b011;
    tick(1);
    flag_clr_i = 3'b000;
    check("R13 other bits untouched", flags_o, 3'b100);
    flag_clr_i = 3'b100;
    tick(2);
    flag_clr_i = 3'b000;
    check("R13 cleared bit", flags_o, 0);
    check("R13 irq dropped", irq_o, 0);

    // R11: falling and either-edge variants
    mode_i = 3'd0;
    tick(1);
    mode_i = 3'd4;
    tick(4);
    check("R11 falling mode idle", status_o, 0);
    trig_i = 1'b0;
    tick(4);
    check("R11 falling edge", status_o, 1);
    mode_i = 3'd0;
    tick(1);
    mode_i = 3'd5;
    tick(2);
    trig_i = 1'b1;
    tick(4);
    check("R11 either edge", status_o, 1);
    mode_i = 3'd0;
    tick(2);
    check("R3 counter wrap", xfer_cnt_o, dones % 16);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule